// File: doc/BRIEF.md
# Serial Register Front End for a Precision Voltage DAC

This block is the digital side of a high-resolution voltage DAC. It is an SPI slave clocked by a fast system clock. It brings the serial clock, chip select and data lines into that clock domain, collects 24-bit frames and decodes each one into a small register file. The register file holds an input code, a clear code, a control word and a set of self-clearing action bits. Its outputs drive the analog stage: the code presented to the converter, the ground clamp, the tri-state control, the reference buffer select, the coding select and the 4-bit linearity trim. It also emits a one-cycle load strobe and a one-cycle clear strobe.

A host writes the input code and then commits it with a load, either through an action bit or by pulling the external load pin low. To read a register, the host sends a read request and then sends a second frame, normally a no-operation write. The register contents shift out on the serial output during that second frame. Narrow converter variants are covered by a code-width parameter. Their codes sit left-justified in the 20-bit field.

Top module: `dac_spi_frontend`

## Requirements
- R1: A frame is 24 bits, sent most significant bit first and sampled on rising serial clock edges. Bit 23 = 1 marks a read and 0 marks a write. Bits 22:20 carry the register address and bits 19:0 carry the payload. The frame takes effect when chip select rises.
- R2: A frame is discarded whole if chip select was low for a number of rising serial clock edges other than 24. This applies to both writes and read requests.
- R3: After the reset input, clamp and tri-state are 1 and every other control output is 0. The output code is 0 and the serial output is not driven.
- R4: Address 2 is the control word. Bit 1 selects the reference buffer, bit 2 clamps the output to ground, bit 3 tri-states the output, bit 4 selects two's-complement coding, bit 5 disables the serial output, and bits 9:6 hold the linearity trim. Bit 0 and bits 19:10 read as 0.
- R5: A write to address 1 (input code) leaves the output code unchanged. The output code takes the input code on a load. A load comes from writing bit 0 of address 4, or occurs for as long as the external load pin is held low.
- R6: Writing bit 1 of address 4 copies the clear code (address 3) to the output code. When the same write also sets bit 0, the clear takes priority.
- R7: Writing bit 2 of address 4 is a software reset. The input code, clear code and output code go to 0, and the control word returns to its reset value (clamp and tri-state 1, all else 0).
- R8: The action bits of address 4 produce one-cycle strobes (load_strobe for bit 0, clear_strobe for bit 1), and address 4 reads back as 0.
- R9: A read request is answered during the next frame. That frame shifts out 1 in bit 23, the requested address in bits 22:20 and the register contents in bits 19:0, most significant bit first. Each serial output bit changes after a falling serial clock edge. A frame that follows a write shifts out zeros.
- R10: With a code width of N bits, the low 20-N bits of the input code, clear code and output code are forced to 0, both when written and when read.
- R11: The serial output enable is high only while chip select is low and control bit 5 is 0. While bit 5 is set, a read answer is all zeros and the output is never enabled.
- R12: Writes to address 0 and to addresses 5 to 7 change nothing, and reads of those addresses return 0 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, must be several times the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| load_n | input | 1 | External load request, active low level |
| spi_miso | output | 1 | Serial data out (0 when not enabled) |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| dac_code | output | 20 | Left-justified code presented to the converter |
| out_clamp_gnd | output | 1 | Clamp converter output to ground |
| out_tristate | output | 1 | Tri-state converter output |
| ref_buf_sel | output | 1 | Reference buffer select |
| twos_comp_sel | output | 1 | Two's-complement coding select |
| lin_comp | output | 4 | Linearity trim code |
| load_strobe | output | 1 | One-cycle pulse on a software load |
| clear_strobe | output | 1 | One-cycle pulse on a software clear |

## Verification
The bench builds the block with a 16-bit code width, so four low bits of every code must vanish. Writes and read-backs can therefore observe the left-justification masking directly. The control word and the input code are each swept through several dozen arithmetically generated patterns. Every pattern is read back over the two-frame protocol. Patterns with the serial-output disable bit set show the silent read path. A two-stage synchronizer and a serial half period of four system clocks exercise the real edge-detection path. Frames of 23 and 25 bits cover the discard rule.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 20;

  typedef enum logic [ADDR_W-1:0] {
    RA_NOP  = 3'd0,
    RA_CODE = 3'd1,
    RA_CTRL = 3'd2,
    RA_CLR  = 3'd3,
    RA_ACT  = 3'd4
  } reg_addr_e;

  // control word bit positions
  localparam int CB_BUF    = 1;
  localparam int CB_CLAMP  = 2;
  localparam int CB_TRI    = 3;
  localparam int CB_CODING = 4;
  localparam int CB_SDOOFF = 5;
  localparam int CB_LIN_LO = 6;
  localparam int CB_TOP    = 9;

  localparam logic [CB_TOP:1] CTRL_RESET = 9'b000000110;  // clamp + tri-state

  // action bit positions
  localparam int AB_LOAD  = 0;
  localparam int AB_CLEAR = 1;
  localparam int AB_RESET = 2;
endpackage

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               sclk_fall,
  output logic               cs_active,
  output logic               frame_end,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [SYNC_STAGES:0]   sclk_s;
  logic [SYNC_STAGES:0]   cs_s;
  logic [SYNC_STAGES-1:0] mosi_s;
  logic [CNT_W-1:0]       bit_cnt;
  logic [FRAME_W-1:0]     shreg;

  logic sclk_now, sclk_prev, cs_now, cs_prev, mosi_now, sclk_rise, cs_rise;

  assign sclk_now  = sclk_s[SYNC_STAGES-1];
  assign sclk_prev = sclk_s[SYNC_STAGES];
  assign cs_now    = cs_s[SYNC_STAGES-1];
  assign cs_prev   = cs_s[SYNC_STAGES];
  assign mosi_now  = mosi_s[SYNC_STAGES-1];
  assign cs_active = ~cs_now;
  assign sclk_rise = sclk_now & ~sclk_prev & cs_active;
  assign sclk_fall = ~sclk_now & sclk_prev & cs_active;
  assign cs_rise   = cs_now & ~cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-1:0], sclk};
      cs_s   <= {cs_s[SYNC_STAGES-1:0], cs_n};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      frame_end  <= 1'b0;
      frame_ok   <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_end <= cs_rise;
      frame_ok  <= cs_rise && (bit_cnt == CNT_FULL);
      if (cs_rise) frame_word <= shreg;
      if (!cs_active) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], mosi_now};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R2: an accepted frame always coincides with a frame end
  a_r2_ok_at_end: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> frame_end);
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int CODE_BITS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ldac_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [CB_TOP:1]   ctrl,
  output logic [DATA_W-1:0] dac_out,
  output logic              load_pulse,
  output logic              clear_pulse
);
  localparam int LOW_ZERO = DATA_W - CODE_BITS;
  localparam logic [DATA_W-1:0] CODE_MASK = {DATA_W{1'b1}} << LOW_ZERO;

  logic [DATA_W-1:0] code_in, clr_code;
  logic              reset_pulse;
  logic              act_hit;

  assign act_hit = wr_en && (wr_addr == RA_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_pulse  <= 1'b0;
      clear_pulse <= 1'b0;
      reset_pulse <= 1'b0;
    end else begin
      load_pulse  <= act_hit && wr_data[AB_LOAD];
      clear_pulse <= act_hit && wr_data[AB_CLEAR];
      reset_pulse <= act_hit && wr_data[AB_RESET];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || reset_pulse) begin
      code_in  <= '0;
      clr_code <= '0;
      ctrl     <= CTRL_RESET;
      dac_out  <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          RA_CODE: code_in  <= wr_data & CODE_MASK;
          RA_CLR:  clr_code <= wr_data & CODE_MASK;
          RA_CTRL: ctrl     <= wr_data[CB_TOP:1];
          default: ;
        endcase
      end
      if (clear_pulse)                 dac_out <= clr_code;
      else if (load_pulse || ldac_req) dac_out <= code_in;
    end
  end

  always_comb begin
    case (rd_addr)
      RA_CODE: rd_data = code_in;
      RA_CLR:  rd_data = clr_code;
      RA_CTRL: rd_data = {{(DATA_W-CB_TOP-1){1'b0}}, ctrl, 1'b0};
      default: rd_data = '0;
    endcase
  end

  // R7: software reset returns the output to the safe clamped state
  a_r7_soft_reset: assert property (@(posedge clk) disable iff (rst)
    reset_pulse |=> (ctrl[CB_CLAMP] && ctrl[CB_TRI] && dac_out == '0));
  // R8: action strobes last exactly one cycle
  a_r8_load_single: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse);
  a_r8_clear_single: assert property (@(posedge clk) disable iff (rst)
    clear_pulse |=> !clear_pulse);
  // R5: output code holds without a load, clear or reset
  a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_pulse && !clear_pulse && !ldac_req && !reset_pulse) |=> $stable(dac_out));
  // R10: unused low bits stay zero
  a_r10_low_zero: assert property (@(posedge clk) disable iff (rst)
    (dac_out & ~CODE_MASK) == '0);
endmodule

// File: rtl/dacif_tx.sv
module dacif_tx
  import dacif_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               sclk_fall,
  input  logic               cs_active,
  input  logic               sdo_off,
  output logic               miso,
  output logic               miso_oe
);
  logic [FRAME_W-1:0] shreg;
  logic               oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= cs_active & ~sdo_off;
      if (load)           shreg <= load_word;
      else if (sclk_fall) shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso    = shreg[FRAME_W-1] & oe_q;
  assign miso_oe = oe_q;

  // R11: a disabled serial output is never driven
  a_r11_sdo_off: assert property (@(posedge clk) disable iff (rst)
    sdo_off |=> !miso_oe);
  // R11: the pad is not driven while chip select is high
  a_r11_idle_off: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> !miso_oe);
endmodule

// File: rtl/dac_spi_frontend.sv
module dac_spi_frontend
  import dacif_pkg::*;
#(
  parameter int CODE_BITS   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  input  logic        load_n,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  output logic [19:0] dac_code,
  output logic        out_clamp_gnd,
  output logic        out_tristate,
  output logic        ref_buf_sel,
  output logic        twos_comp_sel,
  output logic [3:0]  lin_comp,
  output logic        load_strobe,
  output logic        clear_strobe
);
  logic               sclk_fall, cs_active, frame_end, frame_ok;
  logic [FRAME_W-1:0] frame_word, tx_word;
  logic [DATA_W-1:0]  rd_data;
  logic [CB_TOP:1]    ctrl;
  logic [SYNC_STAGES-1:0] ldac_s;
  logic               is_read;
  logic [ADDR_W-1:0]  f_addr;

  always_ff @(posedge clk) begin
    if (rst) ldac_s <= '1;
    else     ldac_s <= {ldac_s[SYNC_STAGES-2:0], load_n};
  end

  assign is_read = frame_word[FRAME_W-1];
  assign f_addr  = frame_word[FRAME_W-2 -: ADDR_W];
  assign tx_word = (frame_ok && is_read) ? {1'b1, f_addr, rd_data} : '0;

  dacif_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_fall(sclk_fall), .cs_active(cs_active), .frame_end(frame_end),
    .frame_ok(frame_ok), .frame_word(frame_word)
  );

  dacif_regs #(.CODE_BITS(CODE_BITS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(frame_ok && !is_read), .wr_addr(f_addr),
    .wr_data(frame_word[DATA_W-1:0]), .rd_addr(f_addr),
    .ldac_req(~ldac_s[SYNC_STAGES-1]), .rd_data(rd_data), .ctrl(ctrl),
    .dac_out(dac_code), .load_pulse(load_strobe), .clear_pulse(clear_strobe)
  );

  dacif_tx u_tx (
    .clk(clk), .rst(rst), .load(frame_end), .load_word(tx_word),
    .sclk_fall(sclk_fall), .cs_active(cs_active), .sdo_off(ctrl[CB_SDOOFF]),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  assign out_clamp_gnd = ctrl[CB_CLAMP];
  assign out_tristate  = ctrl[CB_TRI];
  assign ref_buf_sel   = ctrl[CB_BUF];
  assign twos_comp_sel = ctrl[CB_CODING];
  assign lin_comp      = ctrl[CB_TOP:CB_LIN_LO];
endmodule

// File: tb/dac_spi_frontend_bench.sv
module dac_spi_frontend_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int CODE_BITS = 16;
  localparam logic [19:0] MASK = 20'hFFFFF << (20 - CODE_BITS);

  logic clk = 0, rst = 1, sclk = 0, cs_n = 1, mosi = 0, load_n = 1;
  logic miso, miso_oe, clamp, tri_o, bufs, twos, lds, clrs;
  logic [19:0] code;
  logic [3:0] lin;
  int n_cmp = 0, n_bad = 0, n_load = 0, n_clear = 0;
  logic oe_seen;
  logic [23:0] got, junk;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_spi_frontend #(.CODE_BITS(CODE_BITS), .SYNC_STAGES(2)) u_dac_spi_frontend (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .load_n(load_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .dac_code(code),
    .out_clamp_gnd(clamp), .out_tristate(tri_o), .ref_buf_sel(bufs),
    .twos_comp_sel(twos), .lin_comp(lin), .load_strobe(lds), .clear_strobe(clrs)
  );

  always @(posedge clk) begin
    if (lds) n_load++;
    if (clrs) n_clear++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [23:0] w, input int nbits, output logic [23:0] r);
    r = '0;
    oe_seen = 1'b0;
    wait_clk(2);
    cs_n = 0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? w[23-i] : 1'b0;
      wait_clk(HALF);
      r = {r[22:0], miso};
      if (miso_oe) oe_seen = 1'b1;
      sclk = 1;
      wait_clk(HALF);
      sclk = 0;
    end
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(8);
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    spi_frame({1'b0, a, d}, 24, junk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] r);
    spi_frame({1'b1, a, 20'h0}, 24, junk);
    spi_frame(24'h0, 24, r);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [19:0] v, c, prev;
    int l0, c0;
    wait_clk(5);
    rst = 0;
    wait_clk(2);
    // R3 reset state
    check("R3 clamp", clamp, 1);
    check("R3 tristate", tri_o, 1);
    check("R3 bufsel", bufs, 0);
    check("R3 coding", twos, 0);
    check("R3 lin", lin, 0);
    check("R3 code", code, 0);
    check("R3 miso_oe", miso_oe, 0);

    // R4 / R9 / R11 control word sweep
    for (int i = 0; i < 48; i++) begin
      v = 20'((i * 149 + 3) & 10'h3FF);
      wr(3'd2, v);
      check("R4 bufsel", bufs, v[1]);
      check("R4 clamp", clamp, v[2]);
      check("R4 tristate", tri_o, v[3]);
      check("R4 coding", twos, v[4]);
      check("R4 lin", lin, v[9:6]);
      rd(3'd2, got);
      if (v[5]) begin
        check("R11 silent readback", got, 0);
        check("R11 oe held low", oe_seen, 0);
      end else begin
        check("R9 R4 ctrl readback", got, {1'b1, 3'd2, v & 20'h3FE});
        check("R11 oe during frame", oe_seen, 1);
      end
    end
    wr(3'd2, 20'h0);

    // R5 / R10 / R8 code sweep
    prev = 20'h0;
    for (int i = 0; i < 40; i++) begin
      c = 20'((i * 26497 + 5) & 20'hFFFFF);
      wr(3'd1, c);
      check("R5 hold before load", code, prev);
      rd(3'd1, got);
      check("R10 R1 code readback", got, {1'b1, 3'd1, c & MASK});
      l0 = n_load;
      wr(3'd4, 20'h1);
      check("R5 sw load", code, c & MASK);
      check("R10 low bits zero", code & ~MASK, 0);
      check("R8 one load strobe", n_load - l0, 1);
      prev = c & MASK;
    end
    rd(3'd4, got);
    check("R8 action reads zero", got, {1'b1, 3'd4, 20'h0});

    // R5 external load pin
    wr(3'd1, 20'hABCDE);
    check("R5 hold no pin", code, prev);
    load_n = 0;
    wait_clk(6);
    load_n = 1;
    wait_clk(4);
    check("R5 pin load", code, 20'hABCDE & MASK);

    // R6 clear and priority
    wr(3'd3, 20'h1234F);
    rd(3'd3, got);
    check("R6 clear code readback", got, {1'b1, 3'd3, 20'h1234F & MASK});
    wr(3'd1, 20'h77777);
    c0 = n_clear;
    wr(3'd4, 20'h3);
    check("R6 clear beats load", code, 20'h1234F & MASK);
    check("R8 one clear strobe", n_clear - c0, 1);
    wr(3'd4, 20'h1);
    check("R6 load after clear", code, 20'h77777 & MASK);
    wr(3'd4, 20'h2);
    check("R6 clear", code, 20'h1234F & MASK);

    // R9 back-to-back reads
    wr(3'd2, 20'h2D2);
    spi_frame({1'b1, 3'd2, 20'h0}, 24, junk);
    spi_frame({1'b1, 3'd3, 20'h0}, 24, got);
    check("R9 first answer", got, {1'b1, 3'd2, 20'h2D2});
    spi_frame(24'h0, 24, got);
    check("R9 second answer", got, {1'b1, 3'd3, 20'h1234F & MASK});
    spi_frame(24'h0, 24, got);
    check("R9 after write zeros", got, 0);

    // R2 malformed frames
    wr(3'd1, 20'h55550);
    spi_frame({1'b0, 3'd1, 20'hFFFFF}, 23, junk);
    spi_frame({1'b0, 3'd1, 20'hFFFFF}, 25, junk);
    spi_frame({1'b0, 3'd2, 20'h008}, 25, junk);
    wr(3'd4, 20'h1);
    check("R2 short/long write ignored", code, 20'h55550);
    check("R2 ctrl untouched", tri_o, 0);
    spi_frame({1'b1, 3'd1, 20'h0}, 23, junk);
    spi_frame(24'h0, 24, got);
    check("R2 short read no answer", got, 0);

    // R12 no-op and unused addresses
    wr(3'd0, 20'hFFFFF);
    wr(3'd5, 20'hFFFFF);
    wr(3'd6, 20'hFFFFF);
    wr(3'd7, 20'hFFFFF);
    check("R12 code unchanged", code, 20'h55550);
    check("R12 lin unchanged", lin, 4'hB);
    check("R12 clamp unchanged", clamp, 0);
    rd(3'd0, got);
    check("R12 nop reads zero", got, {1'b1, 3'd0, 20'h0});
    rd(3'd6, got);
    check("R12 addr6 reads zero", got, {1'b1, 3'd6, 20'h0});

    // R7 software reset
    wr(3'd4, 20'h4);
    check("R7 clamp", clamp, 1);
    check("R7 tristate", tri_o, 1);
    check("R7 lin", lin, 0);
    check("R7 bufsel", bufs, 0);
    check("R7 code", code, 0);
    rd(3'd2, got);
    check("R7 ctrl readback", got, {1'b1, 3'd2, 20'h00C});
    rd(3'd1, got);
    check("R7 input code", got, {1'b1, 3'd1, 20'h0});
    rd(3'd3, got);
    check("R7 clear code", got, {1'b1, 3'd3, 20'h0});
    wr(3'd4, 20'h1);
    check("R7 load after reset", code, 0);

    finish_run();
  end
endmodule